// File: doc/BRIEF.md
# Time-Multiplexed Spiking Neuron Element

This block advances a population of quadratic two-variable spiking neurons by one forward-Euler step per sweep. Every neuron has a membrane potential V, a recovery variable u and an input current I. All three are held in local storage indexed by neuron number. One deep fixed-point pipeline is shared by every neuron: a sweep issues neurons 0 to n-1, one per clock, and writes each updated V and u back at the pipeline's last stage. A neuron whose new potential reaches the peak value is reset and its recovery variable is bumped. Its index is then appended to a local list of fired neurons, and a sticky flag is raised.

A controller first issues a clear, which puts every neuron at its resting state. It then loads currents, either as raw fixed-point values or as on/off pixel enables that select a fixed drive current. After that it issues one start per simulation time step. After each done pulse it reads the fired-index list to feed the next layer.

Top module: `spk_neuron_pe`

## Requirements
- R1: After reset `busy`, `done` and `fired` are low and `fire_count` is 0.
- R2: Values are signed 32-bit fixed point with 12 fraction bits. A product p of two values is taken as floor(p/4096). One step computes V' = sat(V + q(164·q(V·V)) + 5·V + 573440 − u + I) and u' = sat(u + q(a·(q(b·V) − u))), where q is the product rule and 573440 is 140·4096.
- R3: When V' ≥ 122880 (30.0), the neuron fires: V is stored as c and u as sat(u' + d). Otherwise V' and u' are stored.
- R4: Parameter set (raw values): `inhib`=0 gives a=82, b=819, c=−225280, d=16384; `inhib`=1 gives a=246, b=901, c=−266240, d=8192. `inhib` is sampled only on the edge that accepts start or clear.
- R5: An accepted clear writes V=c, u=sat(floor(b·c/4096)) and I=0 into all N_MAX neurons, one per clock. `done` pulses N_MAX edges after the edge that accepted clear.
- R6: While idle, `cur_we` writes `cur_data` into I of neuron `cur_addr`. Otherwise `pix_we` writes PIX_CURRENT (default 40960) if `pix_on` is 1, and 0 if it is 0. `cur_we` wins when both are set. Both writes are ignored while `busy`.
- R7: A sweep updates neurons 0 to min(n_count, N_MAX)−1 exactly once each, in ascending order. Neurons above that range keep their state.
- R8: An accepted start or clear empties the fired list and lowers `fired`. Each firing neuron's index is appended in ascending order, `fire_count` grows by one per firing, and `fired` stays high until the next accepted command. Entry k is read combinationally at `fire_rd_addr`=k.
- R9: `done` is a single-cycle pulse on the (STAGES + n)-th rising edge after the edge that accepted start, where n is the clamped count. `busy` is high in between and low with `done`.
- R10: A start with `n_count`=0 updates no neuron and raises `done` on the edge that accepts it, with an empty list.
- R11: Write-back saturates to the 32-bit signed range. An extreme positive current therefore fires in one step rather than wrapping, and an extreme negative current pins V at the minimum.
- R12: Start and clear are ignored while `busy`. The running sweep ends on time and the neuron states are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one update sweep |
| clear | input | 1 | Begin the resting-state initialisation walk |
| inhib | input | 1 | Parameter set select, sampled with start/clear |
| n_count | input | CNT_W | Number of neurons in the sweep |
| cur_we | input | 1 | Raw current write strobe |
| cur_addr | input | IDX_W | Neuron index for current writes |
| cur_data | input | 32 | Raw fixed-point current |
| pix_we | input | 1 | Pixel current write strobe |
| pix_on | input | 1 | Pixel state for pix_we |
| fire_rd_addr | input | IDX_W | Fired-list read position |
| busy | output | 1 | Sweep or clear walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fired | output | 1 | Sticky: some neuron fired this sweep |
| fire_count | output | CNT_W | Entries in the fired list |
| fire_rd_idx | output | IDX_W | Neuron index at fire_rd_addr |

## Verification
The update arithmetic is driven three ways: by random on/off pixel maps over many consecutive steps, which exposes errors in the slow build-up of V and u; by random raw currents of both signs, which separates mistakes in sign and rounding; and by the two extreme current values, which distinguish saturation from wrap-around. Sweeps of random length, a zero-length sweep and an over-long count separate the issue range, the clamp and the list order. Strobes, starts and clears raised during a sweep show whether the idle-only gating holds. Both parameter sets are run from a fresh clear, which shows whether `inhib` is latched.

// File: rtl/spk_pkg.sv
`timescale 1ns/1ps
package spk_pkg;

    localparam int FRAC_BITS = 12;
    localparam int INT_BITS  = 20;
    localparam int VW        = INT_BITS + FRAC_BITS;
    localparam int AW        = 2 * VW;

    typedef logic signed [VW-1:0] fx_t;
    typedef logic signed [AW-1:0] acc_t;

    function automatic acc_t hundredths(int n);
        return acc_t'((n * (1 << FRAC_BITS) + 50) / 100);
    endfunction

    localparam acc_t ONE    = acc_t'(1) <<< FRAC_BITS;
    localparam acc_t K_SQ   = hundredths(4);
    localparam acc_t K_LIN  = acc_t'(5);
    localparam acc_t K_OFS  = acc_t'(140) * ONE;
    localparam acc_t V_PEAK = acc_t'(30) * ONE;
    localparam acc_t FX_MAX = (acc_t'(1) <<< (VW - 1)) - acc_t'(1);
    localparam acc_t FX_MIN = -(acc_t'(1) <<< (VW - 1));

    typedef struct packed {
        fx_t a;
        fx_t b;
        fx_t c;
        fx_t d;
    } nparam_t;

    typedef enum logic [1:0] {PE_IDLE, PE_INIT, PE_RUN} pe_mode_e;

    function automatic acc_t qmul(acc_t x, acc_t y);
        acc_t p;
        p = x * y;
        return p >>> FRAC_BITS;
    endfunction

    function automatic fx_t fx_sat(acc_t x);
        if (x > FX_MAX) return fx_t'(FX_MAX);
        if (x < FX_MIN) return fx_t'(FX_MIN);
        return fx_t'(x);
    endfunction

    function automatic nparam_t pick_params(logic inhib);
        nparam_t p;
        if (inhib) begin
            p.a = fx_t'(hundredths(6));
            p.b = fx_t'(hundredths(22));
            p.c = fx_t'(acc_t'(-65) * ONE);
            p.d = fx_t'(acc_t'(2) * ONE);
        end else begin
            p.a = fx_t'(hundredths(2));
            p.b = fx_t'(hundredths(20));
            p.c = fx_t'(acc_t'(-55) * ONE);
            p.d = fx_t'(acc_t'(4) * ONE);
        end
        return p;
    endfunction

endpackage

// File: rtl/spk_state_mem.sv
`timescale 1ns/1ps
module spk_state_mem import spk_pkg::*; #(
    parameter int DEPTH = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             vu_we,
    input  logic [IDX_W-1:0] vu_addr,
    input  fx_t              vu_v,
    input  fx_t              vu_u,
    input  logic             i_we,
    input  logic [IDX_W-1:0] i_addr,
    input  fx_t              i_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_addr,
    output fx_t              rd_v,
    output fx_t              rd_u,
    output fx_t              rd_i
);
    fx_t mem_v [DEPTH];
    fx_t mem_u [DEPTH];
    fx_t mem_i [DEPTH];

    always_ff @(posedge clk) begin
        if (vu_we) begin
            mem_v[vu_addr] <= vu_v;
            mem_u[vu_addr] <= vu_u;
        end
        if (i_we) mem_i[i_addr] <= i_data;
        if (rd_en) begin
            rd_v <= mem_v[rd_addr];
            rd_u <= mem_u[rd_addr];
            rd_i <= mem_i[rd_addr];
        end
    end
endmodule

// File: rtl/spk_step_pipe.sv
`timescale 1ns/1ps
module spk_step_pipe import spk_pkg::*; #(
    parameter int STAGES = 23,
    parameter int IDX_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  nparam_t          prm,
    input  logic             in_vld,
    input  logic             in_last,
    input  logic [IDX_W-1:0] in_idx,
    input  fx_t              in_v,
    input  fx_t              in_u,
    input  fx_t              in_i,
    output logic             out_vld,
    output logic             out_last,
    output logic [IDX_W-1:0] out_idx,
    output fx_t              out_v,
    output fx_t              out_u,
    output logic             out_fire
);
    // stage 1 is the state read register outside; stages 2..4 compute
    localparam int PAD = STAGES - 4;

    typedef struct packed {
        logic             vld;
        logic             last;
        logic [IDX_W-1:0] idx;
    } tag_t;

    typedef struct packed {
        tag_t tg;
        fx_t  v;
        fx_t  u;
        logic fire;
    } res_t;

    tag_t t2_q, t3_q;
    acc_t sq2_q, bv2_q, v2_q, u2_q, base2_q;
    acc_t v3_q, u3_q, dv3_q, du3_q;
    res_t r4_d, r4_q, out_t;

    always_ff @(posedge clk) begin
        if (rst) begin
            t2_q <= '0;
            t3_q <= '0;
        end else begin
            t2_q <= '{vld: in_vld, last: in_last, idx: in_idx};
            t3_q <= t2_q;
        end
        sq2_q   <= qmul(acc_t'(in_v), acc_t'(in_v));
        bv2_q   <= qmul(acc_t'(prm.b), acc_t'(in_v));
        v2_q    <= acc_t'(in_v);
        u2_q    <= acc_t'(in_u);
        base2_q <= K_OFS - acc_t'(in_u) + acc_t'(in_i);
        v3_q    <= v2_q;
        u3_q    <= u2_q;
        dv3_q   <= qmul(K_SQ, sq2_q) + K_LIN * v2_q + base2_q;
        du3_q   <= qmul(acc_t'(prm.a), bv2_q - u2_q);
    end

    always_comb begin
        fx_t  vn, un;
        logic spike;
        vn    = fx_sat(v3_q + dv3_q);
        un    = fx_sat(u3_q + du3_q);
        spike = acc_t'(vn) >= V_PEAK;
        r4_d.tg   = t3_q;
        r4_d.fire = spike & t3_q.vld;
        r4_d.v    = spike ? prm.c : vn;
        r4_d.u    = spike ? fx_sat(acc_t'(un) + acc_t'(prm.d)) : un;
    end

    always_ff @(posedge clk) begin
        if (rst) r4_q <= '0;
        else     r4_q <= r4_d;
    end

    generate
        if (PAD == 0) begin : g_nopad
            assign out_t = r4_q;
        end else begin : g_pad
            res_t chain [PAD];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int k = 0; k < PAD; k++) chain[k] <= '0;
                end else begin
                    chain[0] <= r4_q;
                    for (int k = 1; k < PAD; k++) chain[k] <= chain[k-1];
                end
            end
            assign out_t = chain[PAD-1];
        end
    endgenerate

    assign out_vld  = out_t.tg.vld;
    assign out_last = out_t.tg.last;
    assign out_idx  = out_t.tg.idx;
    assign out_v    = out_t.v;
    assign out_u    = out_t.u;
    assign out_fire = out_t.fire;
endmodule

// File: rtl/spk_fire_list.sv
`timescale 1ns/1ps
module spk_fire_list #(
    parameter int DEPTH = 32,
    parameter int IDX_W = 5,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] count,
    output logic             flag
);
    logic [IDX_W-1:0] slots [DEPTH];
    logic             room;

    assign room = count < CNT_W'(DEPTH);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
            flag  <= 1'b0;
        end else if (push && room) begin
            count <= count + 1'b1;
            flag  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && room && !clr) slots[count[IDX_W-1:0]] <= push_idx;
    end

    assign rd_idx = slots[rd_addr];
endmodule

// File: rtl/spk_neuron_pe.sv
`timescale 1ns/1ps
module spk_neuron_pe import spk_pkg::*; #(
    parameter  int N_MAX       = 32,
    parameter  int STAGES      = 23,
    parameter  int PIX_CURRENT = 40960,
    localparam int IDX_W       = (N_MAX > 1) ? $clog2(N_MAX) : 1,
    localparam int CNT_W       = $clog2(N_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             clear,
    input  logic             inhib,
    input  logic [CNT_W-1:0] n_count,
    input  logic             cur_we,
    input  logic [IDX_W-1:0] cur_addr,
    input  logic [VW-1:0]    cur_data,
    input  logic             pix_we,
    input  logic             pix_on,
    input  logic [IDX_W-1:0] fire_rd_addr,
    output logic             busy,
    output logic             done,
    output logic             fired,
    output logic [CNT_W-1:0] fire_count,
    output logic [IDX_W-1:0] fire_rd_idx
);
    pe_mode_e         mode_q;
    logic [CNT_W-1:0] walk_q, n_lat_q, n_clamp;
    nparam_t          prm_q;
    logic             done_q;
    logic             s1_vld_q, s1_last_q;
    logic [IDX_W-1:0] s1_idx_q;
    logic             idle, issue, list_clr;

    logic             p_vld, p_last, p_fire;
    logic [IDX_W-1:0] p_idx;
    fx_t              p_v, p_u, m_v, m_u, m_i;

    logic             vu_we, i_we;
    logic [IDX_W-1:0] vu_addr, i_addr;
    fx_t              vu_v, vu_u, i_data, init_u;

    assign idle     = mode_q == PE_IDLE;
    assign issue    = (mode_q == PE_RUN) && (walk_q < n_lat_q);
    assign list_clr = idle && (start || clear);
    assign n_clamp  = (n_count > CNT_W'(N_MAX)) ? CNT_W'(N_MAX) : n_count;
    assign init_u   = fx_sat(qmul(acc_t'(prm_q.b), acc_t'(prm_q.c)));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= PE_IDLE;
            walk_q    <= '0;
            n_lat_q   <= '0;
            prm_q     <= '0;
            done_q    <= 1'b0;
            s1_vld_q  <= 1'b0;
            s1_last_q <= 1'b0;
            s1_idx_q  <= '0;
        end else begin
            done_q    <= 1'b0;
            s1_vld_q  <= issue;
            s1_last_q <= issue && (walk_q == n_lat_q - 1'b1);
            s1_idx_q  <= walk_q[IDX_W-1:0];
            case (mode_q)
                PE_IDLE: begin
                    if (clear) begin
                        prm_q  <= pick_params(inhib);
                        walk_q <= '0;
                        mode_q <= PE_INIT;
                    end else if (start) begin
                        prm_q   <= pick_params(inhib);
                        walk_q  <= '0;
                        n_lat_q <= n_clamp;
                        if (n_clamp == '0) done_q <= 1'b1;
                        else               mode_q <= PE_RUN;
                    end
                end
                PE_INIT: begin
                    walk_q <= walk_q + 1'b1;
                    if (walk_q == CNT_W'(N_MAX - 1)) begin
                        mode_q <= PE_IDLE;
                        done_q <= 1'b1;
                    end
                end
                PE_RUN: begin
                    if (issue) walk_q <= walk_q + 1'b1;
                    if (p_vld && p_last) begin
                        mode_q <= PE_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: mode_q <= PE_IDLE;
            endcase
        end
    end

    // state write ports: clear walk, pipeline write-back, host current writes
    always_comb begin
        vu_we   = 1'b0;
        vu_addr = p_idx;
        vu_v    = p_v;
        vu_u    = p_u;
        i_we    = 1'b0;
        i_addr  = cur_addr;
        i_data  = fx_t'(cur_data);
        case (mode_q)
            PE_INIT: begin
                vu_we   = 1'b1;
                vu_addr = walk_q[IDX_W-1:0];
                vu_v    = prm_q.c;
                vu_u    = init_u;
                i_we    = 1'b1;
                i_addr  = walk_q[IDX_W-1:0];
                i_data  = '0;
            end
            PE_RUN: vu_we = p_vld;
            default: begin
                if (cur_we) begin
                    i_we = 1'b1;
                end else if (pix_we) begin
                    i_we   = 1'b1;
                    i_data = pix_on ? fx_t'(PIX_CURRENT) : '0;
                end
            end
        endcase
    end

    spk_state_mem #(.DEPTH(N_MAX), .IDX_W(IDX_W)) u_mem (
        .clk     (clk),
        .vu_we   (vu_we),
        .vu_addr (vu_addr),
        .vu_v    (vu_v),
        .vu_u    (vu_u),
        .i_we    (i_we),
        .i_addr  (i_addr),
        .i_data  (i_data),
        .rd_en   (issue),
        .rd_addr (walk_q[IDX_W-1:0]),
        .rd_v    (m_v),
        .rd_u    (m_u),
        .rd_i    (m_i)
    );

    spk_step_pipe #(.STAGES(STAGES), .IDX_W(IDX_W)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .prm      (prm_q),
        .in_vld   (s1_vld_q),
        .in_last  (s1_last_q),
        .in_idx   (s1_idx_q),
        .in_v     (m_v),
        .in_u     (m_u),
        .in_i     (m_i),
        .out_vld  (p_vld),
        .out_last (p_last),
        .out_idx  (p_idx),
        .out_v    (p_v),
        .out_u    (p_u),
        .out_fire (p_fire)
    );

    spk_fire_list #(.DEPTH(N_MAX), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_list (
        .clk      (clk),
        .rst      (rst),
        .clr      (list_clr),
        .push     (p_vld && p_fire && (mode_q == PE_RUN)),
        .push_idx (p_idx),
        .rd_addr  (fire_rd_addr),
        .rd_idx   (fire_rd_idx),
        .count    (fire_count),
        .flag     (fired)
    );

    assign busy = !idle;
    assign done = done_q;
endmodule

// File: rtl/spk_neuron_pe_chk.sv
`timescale 1ns/1ps
module spk_neuron_pe_chk #(
    parameter  int N_MAX = 32,
    localparam int CNT_W = $clog2(N_MAX + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             clear,
    input logic             busy,
    input logic             done,
    input logic             fired,
    input logic [CNT_W-1:0] fire_count
);
    a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r12_done_while_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r8_list_cleared: assert property (@(posedge clk) disable iff (rst)
        (!busy && (start || clear)) |=> (fire_count == '0 && !fired));

    a_r8_count_steps: assert property (@(posedge clk) disable iff (rst)
        busy |=> (fire_count == $past(fire_count) || fire_count == $past(fire_count) + 1'b1));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (busy && fired) |=> fired);

    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        fire_count <= CNT_W'(N_MAX));
endmodule

bind spk_neuron_pe spk_neuron_pe_chk #(.N_MAX(N_MAX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .clear      (clear),
    .busy       (busy),
    .done       (done),
    .fired      (fired),
    .fire_count (fire_count)
);

// File: tb/spk_neuron_pe_bench.sv
`timescale 1ns/1ps
module spk_neuron_pe_bench;
    localparam int N   = 32;
    localparam int ST  = 23;
    localparam int PIX = 40960;
    localparam int CW  = $clog2(N + 1);
    localparam int IW  = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0, clear = 1'b0, inhib = 1'b0;
    logic [CW-1:0] n_count = '0;
    logic          cur_we = 1'b0, pix_we = 1'b0, pix_on = 1'b0;
    logic [IW-1:0] cur_addr = '0, fire_rd_addr = '0;
    logic [31:0]   cur_data = '0;
    logic          busy, done, fired;
    logic [CW-1:0] fire_count;
    logic [IW-1:0] fire_rd_idx;

    int n_tests = 0;
    int n_fail  = 0;
    int total_fires = 0;

    longint mv [N];
    longint mu [N];
    longint mi [N];

    always #2.5 clk = ~clk;

    spk_neuron_pe u_spk_neuron_pe (
        .clk(clk), .rst(rst), .start(start), .clear(clear), .inhib(inhib),
        .n_count(n_count), .cur_we(cur_we), .cur_addr(cur_addr), .cur_data(cur_data),
        .pix_we(pix_we), .pix_on(pix_on), .fire_rd_addr(fire_rd_addr),
        .busy(busy), .done(done), .fired(fired), .fire_count(fire_count),
        .fire_rd_idx(fire_rd_idx)
    );

    task automatic check(bit ok, string req, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint qm(longint x, longint y);
        return (x * y) >>> 12;
    endfunction

    function automatic longint sat(longint x);
        if (x > 64'sd2147483647) return 64'sd2147483647;
        if (x < -64'sd2147483648) return -64'sd2147483648;
        return x;
    endfunction

    function automatic void prm(bit inh, output longint a, output longint b,
                                output longint c, output longint d);
        if (inh) begin a = 246; b = 901; c = -266240; d = 8192; end
        else     begin a = 82;  b = 819; c = -225280; d = 16384; end
    endfunction

    // R2 R3: one forward step of neuron k, returns 1 when it fires
    function automatic bit step(int k, bit inh);
        longint a, b, c, d, v, u, vn, un;
        prm(inh, a, b, c, d);
        v  = mv[k];
        u  = mu[k];
        vn = sat(v + qm(164, qm(v, v)) + 5 * v + 573440 - u + mi[k]);
        un = sat(u + qm(a, qm(b, v) - u));
        if (vn >= 122880) begin
            mv[k] = c;
            mu[k] = sat(un + d);
            return 1'b1;
        end
        mv[k] = vn;
        mu[k] = un;
        return 1'b0;
    endfunction

    task automatic wr_cur(int k, longint val);
        @(negedge clk);
        cur_we = 1'b1; cur_addr = IW'(k); cur_data = 32'(val);
        @(negedge clk);
        cur_we = 1'b0;
        mi[k] = val;
    endtask

    task automatic wr_pix(int k, bit on);
        @(negedge clk);
        pix_we = 1'b1; pix_on = on; cur_addr = IW'(k);
        @(negedge clk);
        pix_we = 1'b0;
        mi[k] = on ? PIX : 0;
    endtask

    task automatic do_clear(bit inh);
        longint a, b, c, d;
        int edges;
        prm(inh, a, b, c, d);
        for (int k = 0; k < N; k++) begin
            mv[k] = c; mu[k] = sat(qm(b, c)); mi[k] = 0;
        end
        @(negedge clk);
        clear = 1'b1; inhib = inh;
        @(negedge clk);
        clear = 1'b0; inhib = !inh;
        edges = 0;
        while (!done && edges < 2000) begin
            @(posedge clk); edges++; @(negedge clk);
        end
        check(edges == N, "R5 clear walk length", edges, N);
        check(fire_count == 0 && !fired, "R8 list empty after clear", fire_count, 0);
        @(negedge clk);
        check(!done && !busy, "R5 done pulse after clear", done, 0);
    endtask

    task automatic do_sweep(int n, bit inh, bit poke);
        int neff, ecnt, edges, exp_edges;
        int eidx [N];
        neff = (n > N) ? N : n;
        ecnt = 0;
        for (int k = 0; k < neff; k++) begin
            if (step(k, inh)) begin eidx[ecnt] = k; ecnt++; end
        end
        total_fires += ecnt;
        exp_edges = (neff == 0) ? 0 : ST + neff;
        @(negedge clk);
        n_count = CW'(n); inhib = inh; start = 1'b1;
        @(negedge clk);
        start = 1'b0; inhib = !inh;
        if (poke && neff > 0) begin
            // R12 R6: all of these arrive while busy and must be ignored
            cur_we = 1'b1; cur_addr = '0; cur_data = 32'h0100_0000;
            pix_we = 1'b1; pix_on = 1'b1; clear = 1'b1; start = 1'b1;
        end
        edges = 0;
        while (!done && edges < 2000) begin
            @(posedge clk); edges++; @(negedge clk);
            cur_we = 1'b0; pix_we = 1'b0; clear = 1'b0; start = 1'b0;
        end
        if (neff == 0)
            check(edges == 0, "R10 zero-length sweep done at once", edges, 0);
        else
            check(edges == exp_edges, "R9 sweep latency", edges, exp_edges);
        check(!busy, "R9 busy low with done", busy, 0);
        check(fire_count == CW'(ecnt), "R8 fire count", fire_count, ecnt);
        check(fired == (ecnt > 0), "R8 fired flag", fired, (ecnt > 0));
        for (int k = 0; k < ecnt; k++) begin
            fire_rd_addr = IW'(k);
            #1;
            check(fire_rd_idx == IW'(eidx[k]), "R3 R7 fired index order", fire_rd_idx, eidx[k]);
        end
        @(negedge clk);
        check(!done, "R9 done single cycle", done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(!busy && !done && !fired && fire_count == 0, "R1 reset state",
              {busy, done, fired}, 0);

        do_clear(1'b0);
        for (int k = 0; k < N; k++) wr_pix(k, ($urandom % 2) == 1);   // R6 pixels
        for (int s = 0; s < 12; s++) do_sweep(N, 1'b0, 1'b0);          // R2 R3 R9

        for (int k = 0; k < N; k++)                                     // R2 random currents
            wr_cur(k, longint'($urandom_range(38 * 4096, 0)) - 8 * 4096);
        for (int s = 0; s < 8; s++) do_sweep(int'($urandom_range(N, 1)), 1'b0, 1'b0); // R7

        do_sweep(0, 1'b0, 1'b0);                                        // R10
        do_sweep(40, 1'b0, 1'b0);                                       // R7 clamp

        // R6: both strobes at once, raw write wins
        @(negedge clk);
        cur_we = 1'b1; pix_we = 1'b1; pix_on = 1'b1; cur_addr = IW'(2); cur_data = 32'(7 * 4096);
        @(negedge clk);
        cur_we = 1'b0; pix_we = 1'b0;
        mi[2] = 7 * 4096;
        do_sweep(N, 1'b0, 1'b0);

        // R11 saturation extremes
        wr_cur(3, 64'sd2147483647);
        wr_cur(5, -64'sd2147483648);
        do_sweep(N, 1'b0, 1'b0);
        do_sweep(N, 1'b0, 1'b0);
        wr_cur(3, 0);
        wr_cur(5, 0);

        // R12 commands and writes during busy
        do_sweep(N, 1'b0, 1'b1);
        do_sweep(N, 1'b0, 1'b0);

        // R4 second parameter set
        do_clear(1'b1);
        for (int k = 0; k < N; k++) wr_pix(k, ($urandom % 3) != 0);
        for (int s = 0; s < 10; s++) do_sweep(N, 1'b1, s == 4);
        do_sweep(int'($urandom_range(N, 1)), 1'b1, 1'b0);

        check(total_fires > 0, "R3 spikes occurred", total_fires, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule